// File: doc/BRIEF.md
# Three-Tap Vertical Flicker Filter

This block smooths interlaced graphics output in the vertical direction. Every output pixel is a weighted blend of three pixels in the same column: one from the line above, one from the line itself and one from the line below. Pixels stream in as 32-bit words, one per cycle when `in_valid` is high. Alpha sits in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0. The first pixel of a line carries `in_sol`, and the first pixel of a frame or field carries `in_sof`. An `in_sof` pixel also counts as a start of line. Two internal line memories of `LINE_W` words hold the two lines that precede the incoming one.

A line is emitted while the line after it is arriving, so each output column appears one line after its input column. The last line of a frame is emitted while the first line of the next frame arrives. The weight set is chosen by a 4-bit code. A small write-only register port loads a staged copy of the settings. The active copy changes only at a frame start, and only when the update has been armed beforehand.

Top module: `vflicker_filter`

## Requirements
- R1: With the enable bit clear, each output pixel equals the input pixel in the same column of the previous line, all 32 bits unchanged.
- R2: With the enable bit set, each colour channel is (s*top + (16-2s)*mid + s*bot + 8) >> 4. The side weight s is 1 for code 0001, 2 for code 0010, 4 for code 0100 and 5 for code 0101.
- R3: Any other code (including 0000) uses s = 0, so the middle pixel passes unchanged.
- R4: With the enable bit set and the alpha-enable bit clear, output bits 31:24 equal the middle pixel's alpha.
- R5: With both the enable and alpha-enable bits set, alpha is filtered with the same formula and weights as the colour channels.
- R6: On the first line of a frame, the top tap uses the middle pixel in place of the missing upper line.
- R7: On the last line of a frame (the line followed by an `in_sof` line), the bottom tap uses the middle pixel in place of the missing lower line.
- R8: Timing of outputs:
  - An accepted input pixel at column c produces `out_valid` two cycles later, carrying column c of the previous line.
  - The first line after reset produces no output.
  - A cycle with `in_valid` low produces no output two cycles later.
- R9: A write to address 0 stores the settings: code in bits 3:0, enable in bit 4 and alpha-enable in bit 5. The write changes nothing until a later `in_sof` pixel is accepted while an update is armed.
- R10: A write to address 1 with bit 0 set arms an update. The first accepted `in_sof` pixel consumes the armed update. That pixel's output and all later outputs use the new settings. A second frame start without re-arming keeps the settings in use.
- R11: After reset, `out_valid` is low and the active settings are code 0000 with both enables clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0: settings, 1: update arm |
| cfg_wdata | input | 6 | Register write data |
| in_valid | input | 1 | Input pixel present |
| in_sol | input | 1 | Input pixel starts a line |
| in_sof | input | 1 | Input pixel starts a frame or field |
| in_pix | input | 32 | Input ARGB pixel |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 32 | Filtered ARGB pixel |

## Verification
The hardest case to reach is the switch of settings at a frame boundary. The pixel that consumes an armed update is the first pixel of a new frame. Its output, however, belongs to the last line of the previous frame, and it must already use the new weights, with its bottom tap replicated. To reach this, the stimulus stores settings and arms the update during idle cycles before a frame start. It also stores settings without arming them and runs a whole frame to show that nothing moved. A one-line frame is also sent, so that the top and bottom replication act on the same line.

// File: rtl/flk_pkg.sv
package flk_pkg;

  localparam int PIX_W  = 32;
  localparam int CHAN_W = 8;
  localparam int N_CHAN = PIX_W / CHAN_W;
  localparam int CFG_W  = 6;

  typedef struct packed {
    logic [3:0] code;
    logic       en;
    logic       alpha_en;
  } flk_cfg_t;

  // side (top/bottom) weight in sixteenths for a select code
  function automatic logic [3:0] side_weight(input logic [3:0] code);
    logic [3:0] w;
    case (code)
      4'b0001: w = 4'd1;
      4'b0010: w = 4'd2;
      4'b0100: w = 4'd4;
      4'b0101: w = 4'd5;
      default: w = 4'd0;
    endcase
    return w;
  endfunction

  // one channel of the three-tap blend, rounded half up
  function automatic logic [7:0] tap3(input logic [7:0] t, input logic [7:0] m,
                                      input logic [7:0] b, input logic [3:0] ws);
    logic [11:0] wc;
    logic [11:0] acc;
    wc  = 12'd16 - {7'd0, ws, 1'b0};
    acc = {8'd0, ws} * ({4'd0, t} + {4'd0, b}) + wc * {4'd0, m} + 12'd8;
    return acc[11:4];
  endfunction

  function automatic logic [31:0] mix_pixel(input logic [31:0] t, input logic [31:0] m,
                                            input logic [31:0] b, input flk_cfg_t cfg);
    logic [3:0]  ws;
    logic [31:0] r;
    ws = side_weight(cfg.code);
    for (int k = 0; k < N_CHAN; k++)
      r[CHAN_W*k +: CHAN_W] = tap3(t[CHAN_W*k +: CHAN_W], m[CHAN_W*k +: CHAN_W],
                                   b[CHAN_W*k +: CHAN_W], ws);
    if (!cfg.alpha_en) r[31:24] = m[31:24];
    if (!cfg.en) r = m;
    return r;
  endfunction

  // every channel of o lies between the smallest and largest tap
  function automatic logic in_span(input logic [31:0] t, input logic [31:0] m,
                                   input logic [31:0] b, input logic [31:0] o);
    logic ok;
    logic [7:0] lo, hi, ct, cm, cb, co;
    ok = 1'b1;
    for (int k = 0; k < N_CHAN; k++) begin
      ct = t[CHAN_W*k +: CHAN_W];
      cm = m[CHAN_W*k +: CHAN_W];
      cb = b[CHAN_W*k +: CHAN_W];
      co = o[CHAN_W*k +: CHAN_W];
      lo = (ct < cm) ? ct : cm;
      lo = (cb < lo) ? cb : lo;
      hi = (ct > cm) ? ct : cm;
      hi = (cb > hi) ? cb : hi;
      if (co < lo || co > hi) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/flk_regs.sv
module flk_regs
  import flk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             addr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             frame_take,
  output flk_cfg_t         cfg_act,
  output logic             upd_pending
);

  flk_cfg_t stg_q, act_q;
  logic     pend_q;
  logic     apply_now;

  assign apply_now = frame_take && pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_q  <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr && !addr) stg_q <= '{code: wdata[3:0], en: wdata[4], alpha_en: wdata[5]};
      if (apply_now) begin
        act_q  <= stg_q;
        pend_q <= 1'b0;
      end else if (wr && addr && wdata[0]) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign cfg_act     = act_q;
  assign upd_pending = pend_q;

  // R9
  cfg_frame_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> $past(frame_take && pend_q));

  // R10
  update_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_take && pend_q) |=> !pend_q);

endmodule

// File: rtl/flk_linebuf.sv
module flk_linebuf
  import flk_pkg::*;
#(
  parameter int LINE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             sol,
  input  logic             sof,
  input  logic [PIX_W-1:0] pix,
  output logic [PIX_W-1:0] tap_top,
  output logic [PIX_W-1:0] tap_mid,
  output logic [PIX_W-1:0] tap_bot,
  output logic             tap_emit
);

  localparam int COL_W = $clog2(LINE_W + 1);
  localparam int IDX_W = (LINE_W > 1) ? $clog2(LINE_W) : 1;

  logic [PIX_W-1:0] mem_mid [LINE_W];
  logic [PIX_W-1:0] mem_top [LINE_W];

  logic [COL_W-1:0] col_q, col_c;
  logic [IDX_W-1:0] idx;
  logic             line_start, in_range;
  logic             mid_valid_q, mid_first_q;
  logic             ln_emit_q, ln_toprep_q, ln_botrep_q;
  logic             emit_c, toprep_c, botrep_c;

  assign line_start = valid && (sol || sof);
  assign col_c      = (sol || sof) ? '0 : col_q;
  assign in_range   = col_c < COL_W'(LINE_W);
  assign idx        = in_range ? IDX_W'(col_c) : '0;

  // context of the line now being emitted (the one held in mem_mid)
  assign emit_c   = line_start ? mid_valid_q : ln_emit_q;
  assign toprep_c = line_start ? mid_first_q : ln_toprep_q;
  assign botrep_c = line_start ? sof         : ln_botrep_q;

  assign tap_mid  = mem_mid[idx];
  assign tap_top  = toprep_c ? tap_mid : mem_top[idx];
  assign tap_bot  = botrep_c ? tap_mid : pix;
  assign tap_emit = valid && in_range && emit_c;

  always_ff @(posedge clk) begin
    if (valid && in_range) begin
      mem_top[idx] <= mem_mid[idx];
      mem_mid[idx] <= pix;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q       <= '0;
      mid_valid_q <= 1'b0;
      mid_first_q <= 1'b0;
      ln_emit_q   <= 1'b0;
      ln_toprep_q <= 1'b0;
      ln_botrep_q <= 1'b0;
    end else if (valid) begin
      col_q <= in_range ? col_c + COL_W'(1) : col_c;
      if (line_start) begin
        ln_emit_q   <= mid_valid_q;
        ln_toprep_q <= mid_first_q;
        ln_botrep_q <= sof;
        mid_valid_q <= 1'b1;
        mid_first_q <= sof;
      end
    end
  end

  // R8
  no_emit_first_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_emit |-> mid_valid_q);

  // R7
  bottom_replica_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_emit && valid && sof) |-> (tap_bot == tap_mid));

endmodule

// File: rtl/flk_mac.sv
module flk_mac
  import flk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] top,
  input  logic [PIX_W-1:0] mid,
  input  logic [PIX_W-1:0] bot,
  input  logic             emit,
  input  flk_cfg_t         cfg,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_valid
);

  logic [PIX_W-1:0] s1_top, s1_mid, s1_bot;
  logic             s1_v;
  logic [PIX_W-1:0] blend;

  always_ff @(posedge clk) begin
    s1_top <= top;
    s1_mid <= mid;
    s1_bot <= bot;
  end

  assign blend = mix_pixel(s1_top, s1_mid, s1_bot, cfg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      s1_v      <= emit;
      out_valid <= s1_v;
      if (s1_v) out_pix <= blend;
    end
  end

  // R1
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !cfg.en) |=> (out_pix == $past(s1_mid)));

  // R2
  span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> in_span($past(s1_top), $past(s1_mid), $past(s1_bot), out_pix));

  // R4
  alpha_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && cfg.en && !cfg.alpha_en) |=> (out_pix[31:24] == $past(s1_mid[31:24])));

endmodule

// File: rtl/vflicker_filter.sv
module vflicker_filter
  import flk_pkg::*;
#(
  parameter int LINE_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_addr,
  input  logic [5:0]  cfg_wdata,
  input  logic        in_valid,
  input  logic        in_sol,
  input  logic        in_sof,
  input  logic [31:0] in_pix,
  output logic        out_valid,
  output logic [31:0] out_pix
);

  flk_cfg_t         cfg_act;
  logic             upd_pending;
  logic             frame_take;
  logic [PIX_W-1:0] tap_top, tap_mid, tap_bot;
  logic             tap_emit;

  assign frame_take = in_valid && in_sof;

  flk_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (cfg_wr),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .frame_take (frame_take),
    .cfg_act    (cfg_act),
    .upd_pending(upd_pending)
  );

  flk_linebuf #(.LINE_W(LINE_W)) u_linebuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (in_valid),
    .sol     (in_sol),
    .sof     (in_sof),
    .pix     (in_pix),
    .tap_top (tap_top),
    .tap_mid (tap_mid),
    .tap_bot (tap_bot),
    .tap_emit(tap_emit)
  );

  flk_mac u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .top      (tap_top),
    .mid      (tap_mid),
    .bot      (tap_bot),
    .emit     (tap_emit),
    .cfg      (cfg_act),
    .out_pix  (out_pix),
    .out_valid(out_valid)
  );

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R11
  reset_state_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!out_valid && cfg_act == '0 && !upd_pending));

endmodule

// File: tb/vflicker_filter_bench.sv
module vflicker_filter_bench;

  localparam int CLK_NS = 10;
  localparam int LW     = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [5:0]  cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_sol = 1'b0;
  logic        in_sof = 1'b0;
  logic [31:0] in_pix = '0;
  logic        out_valid;
  logic [31:0] out_pix;

  vflicker_filter #(.LINE_W(LW)) u_vflicker_filter (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sol(in_sol),
    .in_sof(in_sof), .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] prev1 [LW];   // line one back
  logic [31:0] prev2 [LW];   // line two back
  bit  have1 = 0, first1 = 0;
  bit  ln_e = 0, ln_t = 0, ln_b = 0;
  int  mcol = 0;
  int  stg_code = 0, act_code = 0;
  bit  stg_en = 0, stg_aen = 0, act_en = 0, act_aen = 0, armed = 0;
  logic [31:0] seed = 32'h1234_5678;

  // two-deep expectation delay
  bit          e1_v = 0, e2_v = 0;
  logic [31:0] e1_d = '0, e2_d = '0;
  string       e1_t = "R8", e2_t = "R8";
  bit          pipe_live = 0;
  string       tag = "R8";

  function automatic int wside(int code);
    if (code == 1) return 1;
    if (code == 2) return 2;
    if (code == 4) return 4;
    if (code == 5) return 5;
    return 0;
  endfunction

  function automatic logic [31:0] expect_pix(logic [31:0] t, logic [31:0] m, logic [31:0] b);
    logic [31:0] r;
    int s, v;
    if (!act_en) return m;
    s = wside(act_code);
    for (int k = 0; k < 4; k++) begin
      v = (s * int'(t[8*k +: 8]) + (16 - 2*s) * int'(m[8*k +: 8]) + s * int'(b[8*k +: 8]) + 8) / 16;
      r[8*k +: 8] = v[7:0];
    end
    if (!act_aen) r[31:24] = m[31:24];
    return r;
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== e2_v) begin
      errors++;
      $display("FAIL %s (R8 valid): got %0b expected %0b", e2_t, out_valid, e2_v);
    end else if (e2_v && out_pix !== e2_d) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", e2_t, out_pix, e2_d);
    end
  endtask

  task automatic step(bit v, bit sol, bit sof, logic [31:0] p, bit wr, bit a, logic [5:0] d);
    bit          ev;
    logic [31:0] ed, t, m, b;
    @(negedge clk);
    if (pipe_live) compare();
    e2_v = e1_v; e2_d = e1_d; e2_t = e1_t;
    in_valid = v; in_sol = sol; in_sof = sof; in_pix = p;
    cfg_wr = wr; cfg_addr = a; cfg_wdata = d;
    ev = 0; ed = '0;
    if (v) begin
      if (sof && armed) begin
        act_code = stg_code; act_en = stg_en; act_aen = stg_aen; armed = 0;
      end
      if (sol || sof) begin
        mcol = 0;
        ln_e = have1; ln_t = first1; ln_b = sof;
        have1 = 1; first1 = sof;
      end
      if (mcol < LW) begin
        m = prev1[mcol];
        t = ln_t ? m : prev2[mcol];
        b = ln_b ? m : p;
        ev = ln_e;
        if (ev) ed = expect_pix(t, m, b);
        prev2[mcol] = prev1[mcol];
        prev1[mcol] = p;
        mcol++;
      end
    end
    if (wr && !a) begin stg_code = int'(d[3:0]); stg_en = d[4]; stg_aen = d[5]; end
    if (wr && a && d[0] && !(v && sof)) armed = 1;
    e1_v = ev; e1_d = ed; e1_t = tag;
    pipe_live = 1;
  endtask

  task automatic idle();
    step(0, 0, 0, '0, 0, 0, '0);
  endtask

  task automatic reg_write(bit a, logic [5:0] d);
    step(0, 0, 0, '0, 1, a, d);
  endtask

  task automatic send_frame(int lines, int gap);
    for (int ln = 0; ln < lines; ln++)
      for (int c = 0; c < LW; c++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        step(1, c == 0, (c == 0) && (ln == 0), seed, 0, 0, '0);
        if (gap != 0 && (c % gap) == gap - 1) idle();
      end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state at the port
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11: got %0b expected 0", out_valid);
    end
    tag = "R11 R1 R8";
    send_frame(4, 3);
    tag = "R9";
    reg_write(0, 6'b01_0100);
    idle();
    send_frame(4, 0);
    tag = "R2 R4 R6 R7 R10";
    reg_write(1, 6'd1);
    send_frame(4, 2);
    tag = "R5";
    reg_write(0, 6'b11_0101);
    reg_write(1, 6'd1);
    send_frame(4, 0);
    tag = "R10";
    reg_write(0, 6'b01_0011);
    send_frame(4, 0);
    tag = "R3";
    reg_write(1, 6'd1);
    send_frame(4, 3);
    tag = "R2 R7";
    reg_write(0, 6'b01_0001);
    reg_write(1, 6'd1);
    send_frame(3, 0);
    tag = "R2 R6";
    reg_write(0, 6'b11_0010);
    reg_write(1, 6'd1);
    send_frame(4, 0);
    tag = "R6 R7";
    send_frame(1, 0);
    send_frame(1, 0);
    tag = "R1 R8";
    reg_write(0, 6'b00_0100);
    reg_write(1, 6'd1);
    send_frame(2, 4);
    idle();
    idle();
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule